// File: doc/BRIEF.md
# Quasi-Random Pattern Receive Sync Monitor

This block checks a received serial bit stream against a locally generated copy of a quasi-random test sequence. It supports two variants. The first is a 20-stage sequence with a limit on zero runs. The second is a 15-stage sequence whose output is inverted. The local reference seeds itself from the incoming bits while the monitor is out of step. Once in step it runs freely, and each received bit is compared with the bit the reference predicts.

Mismatches are counted over consecutive windows of 128 received bits. A window with few errors declares the pattern found. A window with many errors declares it lost. Every change of that status sets a sticky change flag, which software clears with a strobe. A maskable, registered interrupt follows the flag. A bit is taken only on cycles where the bit enable is high and the monitor is switched on, which normally happens whenever the transmit side sends the test pattern.

Top module: `qrss_sync_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sync_o`, `trans_o` and `irq_o` are 0, and the 128-bit window begins again at the next accepted bit.
- R2: A bit is accepted only on a cycle with `bit_en` = 1 and `mon_on` = 1. Windows are exactly 128 accepted bits long. `sync_o` changes only on the clock edge that takes the last bit of a window, or when `mon_on` is low.
- R3: When out of sync, a window with fewer than 4 errors raises `sync_o` to 1 at that window's final edge. A window with 4 or more errors leaves `sync_o` at 0.
- R4: When in sync, a window with more than 4 errors drops `sync_o` to 0 at that window's final edge. A window with exactly 4 errors keeps it at 1.
- R5: With `mode_e1` = 0, the reference is the 20-stage sequence. Its raw bit is the XOR of the bits produced 20 and 17 bits earlier. The bit on the line equals the raw bit, except that after 14 zeros in a row it is forced to 1.
- R6: With `mode_e1` = 1, the reference is the 15-stage sequence. Its raw bit is the XOR of the bits produced 15 and 14 bits earlier, and the line carries the inverted raw bit. A stream sent without the inversion never reaches sync.
- R7: While out of sync, the reference loads the received bits, after removing the inversion, into its history. In sync it runs freely, so bit errors in the received stream do not corrupt it. A clean window that follows a window with errors reports no loss.
- R8: `trans_o` goes to 1 on every change of `sync_o` and stays at 1 until a cycle with `flag_clr` = 1. When a change and a clear happen on the same cycle, the flag stays at 1.
- R9: `irq_o` is registered and equals the new value of `trans_o` ANDed with NOT `irq_mask`. A mask change shows up at `irq_o` one cycle later.
- R10: Lowering `mon_on` forces `sync_o` to 0 on the next edge without setting `trans_o`, and restarts the window. The reference keeps its state while `mon_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_on | input | 1 | Monitor on (test pattern mode selected) |
| bit_en | input | 1 | Received bit valid on this cycle |
| rx_bit | input | 1 | Received data bit |
| mode_e1 | input | 1 | 0: 20-stage zero-limited sequence, 1: 15-stage inverted sequence |
| flag_clr | input | 1 | Clear strobe for the change flag |
| irq_mask | input | 1 | 1 masks the interrupt, 0 enables it |
| sync_o | output | 1 | 1 while the pattern is in sync |
| trans_o | output | 1 | Sticky sync-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The monitor is driven with clean streams of both sequence variants, so that self-seeding and lock are shown to work for each polynomial. A stream of the 15-stage variant without the inversion shows that the inversion is applied and is not a don't-care. Windows with flips placed at exact positions separate the thresholds: 3 against 4 errors while out of sync, and 4 against 5 errors while in sync. A clean window after errors shows that the reference runs freely in sync rather than reloading. Gaps in the bit enable, a clear on the same cycle as a status change, mask toggling and switching the monitor off cover the flag and interrupt path and the rules on window alignment.

// File: rtl/qrss_mon_pkg.sv
package qrss_mon_pkg;
  typedef enum logic {
    SEQ_LONG_ZLIM = 1'b0,
    SEQ_SHORT_INV = 1'b1
  } qrss_seq_e;

  localparam int LONG_LEN   = 20;
  localparam int LONG_TAP   = 17;
  localparam int SHORT_LEN  = 15;
  localparam int SHORT_TAP  = 14;
  localparam int ZERO_LIMIT = 14;
endpackage

// File: rtl/qrss_ref_gen.sv
module qrss_ref_gen
  import qrss_mon_pkg::*;
#(
  parameter int LONG_N   = LONG_LEN,
  parameter int LONG_T   = LONG_TAP,
  parameter int SHORT_N  = SHORT_LEN,
  parameter int SHORT_T  = SHORT_TAP,
  parameter int ZMAX     = ZERO_LIMIT
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic sel_e1,
  input  logic rx_bit,
  input  logic locked,
  output logic bit_err
);
  localparam int ZW = $clog2(ZMAX + 1);

  qrss_seq_e        seq;
  logic [LONG_N-1:0] hist;
  logic [ZW-1:0]     zrun;
  logic              fb, forced, exp_bit, load_bit, seen_bit;

  assign seq = qrss_seq_e'(sel_e1);

  always_comb begin
    if (seq == SEQ_SHORT_INV) fb = hist[SHORT_N-1] ^ hist[SHORT_T-1];
    else                      fb = hist[LONG_N-1] ^ hist[LONG_T-1];
    forced   = (seq == SEQ_LONG_ZLIM) && (zrun == ZW'(ZMAX));
    exp_bit  = (seq == SEQ_SHORT_INV) ? ~fb : (fb | forced);
    bit_err  = rx_bit ^ exp_bit;
    // Seeding: take the raw bit back out of the line bit; a forced one carries no raw info
    if (locked || forced) load_bit = fb;
    else                  load_bit = (seq == SEQ_SHORT_INV) ? ~rx_bit : rx_bit;
    seen_bit = locked ? exp_bit : rx_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      zrun <= '0;
    end else if (bit_stb) begin
      hist <= {hist[LONG_N-2:0], load_bit};
      if (seen_bit)                zrun <= '0;
      else if (zrun != ZW'(ZMAX))  zrun <= zrun + 1'b1;
    end
  end

  AST_FREE_RUN_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && locked) |=> (hist[0] == $past(fb)))
    else $error("reference reloaded while in sync"); // R7
endmodule

// File: rtl/qrss_err_window.sv
module qrss_err_window #(
  parameter int WIN        = 128,
  parameter int LOCK_BELOW = 4,
  parameter int LOSS_ABOVE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_on,
  input  logic bit_en,
  input  logic bit_err,
  output logic sync_q,
  output logic sync_chg
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int EW = $clog2(WIN + 1);

  logic [CW-1:0] pos;
  logic [EW-1:0] errs, total;
  logic          stb, last, sync_next;

  assign stb   = bit_en & mon_on;
  assign last  = stb && (pos == CW'(WIN - 1));
  assign total = errs + {{(EW-1){1'b0}}, bit_err};

  always_comb begin
    sync_next = sync_q;
    sync_chg  = 1'b0;
    if (!mon_on) begin
      sync_next = 1'b0;
    end else if (last) begin
      if (!sync_q && (total < EW'(LOCK_BELOW))) begin
        sync_next = 1'b1;
        sync_chg  = 1'b1;
      end else if (sync_q && (total > EW'(LOSS_ABOVE))) begin
        sync_next = 1'b0;
        sync_chg  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      errs   <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_next;
      if (!mon_on) begin
        pos  <= '0;
        errs <= '0;
      end else if (stb) begin
        if (last) begin
          pos  <= '0;
          errs <= '0;
        end else begin
          pos  <= pos + 1'b1;
          errs <= total;
        end
      end
    end
  end

  AST_SYNC_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (mon_on && !last) |=> $stable(sync_q))
    else $error("sync moved inside a window"); // R2
  AST_OFF_DROPS_SYNC: assert property (@(posedge clk) disable iff (rst)
    !mon_on |=> !sync_q)
    else $error("sync held while monitor off"); // R10
  AST_FOUR_KEEPS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (last && sync_q && (total == EW'(LOSS_ABOVE))) |=> sync_q)
    else $error("sync lost on boundary count"); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    errs <= EW'(WIN))
    else $error("error counter overflow"); // R2
endmodule

// File: rtl/qrss_flag_irq.sv
module qrss_flag_irq (
  input  logic clk,
  input  logic rst,
  input  logic chg,
  input  logic clr,
  input  logic mask,
  output logic flag_q,
  output logic irq_q
);
  logic flag_next;

  assign flag_next = chg | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_next;
      irq_q  <= flag_next & ~mask;
    end
  end

  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    chg |=> flag_q)
    else $error("change not flagged"); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q)
    else $error("flag dropped without clear"); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq_q)
    else $error("masked interrupt raised"); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q)
    else $error("interrupt without flag"); // R9
endmodule

// File: rtl/qrss_sync_monitor.sv
module qrss_sync_monitor
  import qrss_mon_pkg::*;
#(
  parameter int WIN_BITS   = 128,
  parameter int LOCK_BELOW = 4,
  parameter int LOSS_ABOVE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_on,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic mode_e1,
  input  logic flag_clr,
  input  logic irq_mask,
  output logic sync_o,
  output logic trans_o,
  output logic irq_o
);
  logic bit_stb, bit_err, sync_q, sync_chg;

  assign bit_stb = bit_en & mon_on;

  qrss_ref_gen #(
    .LONG_N (LONG_LEN),
    .LONG_T (LONG_TAP),
    .SHORT_N(SHORT_LEN),
    .SHORT_T(SHORT_TAP),
    .ZMAX   (ZERO_LIMIT)
  ) u_ref (
    .clk    (clk),
    .rst    (rst),
    .bit_stb(bit_stb),
    .sel_e1 (mode_e1),
    .rx_bit (rx_bit),
    .locked (sync_q),
    .bit_err(bit_err)
  );

  qrss_err_window #(
    .WIN       (WIN_BITS),
    .LOCK_BELOW(LOCK_BELOW),
    .LOSS_ABOVE(LOSS_ABOVE)
  ) u_win (
    .clk     (clk),
    .rst     (rst),
    .mon_on  (mon_on),
    .bit_en  (bit_en),
    .bit_err (bit_err),
    .sync_q  (sync_q),
    .sync_chg(sync_chg)
  );

  qrss_flag_irq u_flag (
    .clk   (clk),
    .rst   (rst),
    .chg   (sync_chg),
    .clr   (flag_clr),
    .mask  (irq_mask),
    .flag_q(trans_o),
    .irq_q (irq_o)
  );

  assign sync_o = sync_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sync_o && !trans_o && !irq_o))
    else $error("outputs active after reset"); // R1
endmodule

// File: tb/sim_qrss_sync_monitor.sv
module sim_qrss_sync_monitor;
  logic clk = 1'b0;
  logic rst, mon_on, bit_en, rx_bit, mode_e1, flag_clr, irq_mask;
  logic sync_o, trans_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [19:0] g_sr;
  int          g_zr;
  logic        g_e1;

  always #5 clk = ~clk;

  qrss_sync_monitor u0 (
    .clk(clk), .rst(rst), .mon_on(mon_on), .bit_en(bit_en), .rx_bit(rx_bit),
    .mode_e1(mode_e1), .flag_clr(flag_clr), .irq_mask(irq_mask),
    .sync_o(sync_o), .trans_o(trans_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Stimulus sequence built from R5 / R6
  task automatic gen_bit(output logic b);
    logic fb;
    if (g_e1) begin
      fb = g_sr[14] ^ g_sr[13];
      g_sr = {g_sr[18:0], fb};
      b = ~fb;
    end else begin
      fb = g_sr[19] ^ g_sr[16];
      g_sr = {g_sr[18:0], fb};
      b = (g_zr == 14) ? 1'b1 : fb;
      g_zr = b ? 0 : g_zr + 1;
    end
  endtask

  task automatic drive_bit(input logic b, input logic clr, input bit gap);
    bit_en = 1'b1; rx_bit = b; flag_clr = clr;
    @(negedge clk);
    bit_en = 1'b0; flag_clr = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic feed_window(input logic [127:0] flips, input bit clr_last,
                             input bit invert, input int gap_every,
                             output logic pre_sync);
    logic b;
    pre_sync = 1'bx;
    for (int i = 0; i < 128; i++) begin
      gen_bit(b);
      if (invert) b = ~b;
      b = b ^ flips[i];
      if (i == 127) pre_sync = sync_o;
      drive_bit(b, clr_last && (i == 127), (gap_every != 0) && (i % gap_every == 0));
    end
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1; mon_on = 0; bit_en = 0; rx_bit = 0; mode_e1 = 0; flag_clr = 0; irq_mask = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 sync after reset", sync_o, 1'b0);
    chk("R1 flag after reset", trans_o, 1'b0);
    chk("R1 irq after reset", irq_o, 1'b0);
  endtask

  task automatic t_long_lock();
    logic p;
    g_e1 = 0; g_sr = 20'h5A3C7; g_zr = 0;
    mode_e1 = 0; mon_on = 1;
    feed_window('0, 0, 0, 0, p);
    feed_window('0, 0, 0, 0, p);
    feed_window('0, 0, 0, 0, p);
    chk("R3 R5 long sequence locks", sync_o, 1'b1);
    chk("R8 flag on lock", trans_o, 1'b1);
    chk("R9 irq on lock", irq_o, 1'b1);
  endtask

  task automatic t_clear();
    pulse_clr();
    chk("R8 flag cleared", trans_o, 1'b0);
    chk("R9 irq follows clear", irq_o, 1'b0);
    chk("R8 sync unaffected by clear", sync_o, 1'b1);
  endtask

  task automatic t_four_in_sync();
    logic [127:0] f;
    logic p;
    f = '0; f[10] = 1; f[40] = 1; f[70] = 1; f[100] = 1;
    feed_window(f, 0, 0, 0, p);
    chk("R4 four errors keep sync", sync_o, 1'b1);
    chk("R4 no change flagged", trans_o, 1'b0);
    feed_window('0, 0, 0, 0, p);
    chk("R7 clean window after errors stays in sync", sync_o, 1'b1);
    chk("R7 no change after clean window", trans_o, 1'b0);
  endtask

  task automatic t_five_in_sync(input logic clr_last);
    logic [127:0] f;
    logic p;
    f = '0; f[5] = 1; f[25] = 1; f[45] = 1; f[65] = 1; f[85] = 1;
    feed_window(f, clr_last, 0, 0, p);
    chk("R2 sync held before window end", p, 1'b1);
    chk("R4 five errors drop sync", sync_o, 1'b0);
    chk("R8 flag on loss", trans_o, 1'b1);
  endtask

  task automatic t_mask();
    irq_mask = 1;
    @(negedge clk);
    chk("R9 mask removes irq", irq_o, 1'b0);
    chk("R9 flag kept under mask", trans_o, 1'b1);
    irq_mask = 0;
    @(negedge clk);
    chk("R9 unmask restores irq", irq_o, 1'b1);
    pulse_clr();
  endtask

  task automatic restart_mode(input logic e1);
    mon_on = 0;
    @(negedge clk);
    mode_e1 = e1;
    g_e1 = e1; g_sr = 20'h3C5A9; g_zr = 0;
    mon_on = 1;
  endtask

  task automatic t_short_uninverted();
    logic p;
    restart_mode(1);
    feed_window('0, 0, 1, 0, p);
    feed_window('0, 0, 1, 0, p);
    feed_window('0, 0, 1, 0, p);
    chk("R6 uninverted short stream never locks", sync_o, 1'b0);
    chk("R6 no flag without lock", trans_o, 1'b0);
  endtask

  task automatic t_short_lock_gaps();
    logic p;
    feed_window('0, 0, 0, 3, p);
    feed_window('0, 0, 0, 3, p);
    feed_window('0, 0, 0, 3, p);
    chk("R6 R2 short sequence locks with enable gaps", sync_o, 1'b1);
    pulse_clr();
  endtask

  task automatic t_off();
    logic p;
    mon_on = 0;
    @(negedge clk);
    chk("R10 monitor off drops sync", sync_o, 1'b0);
    chk("R10 no flag from switch off", trans_o, 1'b0);
    repeat (3) drive_bit(1'b1, 0, 0);
    mon_on = 1;
    feed_window('0, 0, 0, 0, p);
    chk("R10 R7 held reference relocks in one window", sync_o, 1'b1);
    chk("R2 sync held low before first window ends", p, 1'b0);
    pulse_clr();
  endtask

  task automatic t_unsync_thresholds();
    logic [127:0] f;
    logic p;
    t_five_in_sync(1);
    chk("R8 change wins over same-cycle clear", trans_o, 1'b1);
    pulse_clr();
    f = '0; f[124] = 1; f[125] = 1; f[126] = 1; f[127] = 1;
    feed_window(f, 0, 0, 0, p);
    chk("R3 four errors do not lock", sync_o, 1'b0);
    feed_window('0, 0, 0, 0, p);
    feed_window('0, 0, 0, 0, p);
    chk("R3 R7 reseeded stream locks", sync_o, 1'b1);
    pulse_clr();
    t_five_in_sync(0);
    pulse_clr();
    f = '0; f[125] = 1; f[126] = 1; f[127] = 1;
    feed_window(f, 0, 0, 0, p);
    chk("R2 unsynced before window end", p, 1'b0);
    chk("R3 three errors lock", sync_o, 1'b1);
    chk("R8 flag on relock", trans_o, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_long_lock();
    t_clear();
    t_four_in_sync();
    t_five_in_sync(0);
    t_mask();
    t_short_uninverted();
    t_short_lock_gaps();
    t_off();
    t_unsync_thresholds();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule